// File: doc/BRIEF.md
# Block Header Predication Decoder

This block examines the first 32-bit word of a 256-bit instruction block and turns it into per-slot control for the eight 32-bit slots of that block. If the leading bit of the word is one, the block has no header. Every slot then holds an ordinary, unpredicated 32-bit instruction. A leading zero means the word is a header. The block sorts headers into three kinds from their top bits: a predication header, a long-instruction header, and a short (16-bit) header.

For a predication header, slot 0 is the header itself. The remaining 28 bits hold one 4-bit field for each of slots 1 through 7. Each field has a sense bit and a 3-bit flag selector. The block reports whether each slot holds an instruction (slot-valid) and whether it may run (execute-enable), judged against an 8-bit condition-flag vector presented with the header word. For the other two header kinds, the block reports only the kind and leaves both masks at zero, because other decoders handle those layouts.

The decode is combinational and feeds one register stage with a clock enable. A result appears one clock after its input is accepted and holds until the next accepted input.

Top module: `blkhdr_pred_decode`

## Requirements
- R1: When bit 31 of the accepted word is 1, the result has kind 0 (no header), slot_valid = 8'hFF and slot_exec = 8'hFF, whatever the flags are.
- R2: Kind encoding: bits [31:28] = 4'b0000 gives kind 1 (predication); bits [31:30] = 2'b00 with bits [29:28] not both zero gives kind 2 (long); bits [31:30] = 2'b01 gives kind 3 (short).
- R3: For kind 1, bit 0 of slot_valid and slot_exec is 0, because slot 0 holds the header. Slot n (1..7) is controlled by the field at bits [31-4n : 28-4n]: slot 1 at [27:24] and slot 7 at [3:0]. Within a field, bit 3 is the sense bit and bits [2:0] are the flag selector.
- R4: For kind 1, a field of 4'b0000 makes the slot valid and enabled, whatever the flags are.
- R5: For kind 1, a field of 4'b1000 makes the slot not valid and not enabled. A slot that is not valid is never enabled.
- R6: For kind 1, a field with sense 0 and selector n (1..7) makes the slot valid, with enable equal to cond_flags[n].
- R7: For kind 1, a field with sense 1 and selector n (1..7) makes the slot valid, with enable equal to the inverse of cond_flags[n].
- R8: For kinds 2 and 3, slot_valid and slot_exec are both 8'h00.
- R9: cond_flags[0] has no effect on any output.
- R10: out_valid is in_valid delayed by one clock, and the results belong to the word and flags accepted one clock earlier. While in_valid is low, kind and masks hold their values.
- R11: After reset, out_valid, hdr_kind, slot_valid and slot_exec are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accept first_word and cond_flags this cycle |
| first_word | input | 32 | First 32-bit word of the instruction block |
| cond_flags | input | 8 | Condition flags; bits 1..7 are selectable |
| out_valid | output | 1 | Result registers hold a new result |
| hdr_kind | output | 2 | 0 none, 1 predication, 2 long, 3 short |
| slot_valid | output | 8 | Bit n set when slot n holds an instruction |
| slot_exec | output | 8 | Bit n set when slot n may execute |

## Verification
The bench targets the two special field codes. A decoder that confused 4'b1000 with a predicated slot would read flag 0 and report the slot as valid. One that missed 4'b0000 would tie the slot to cond_flags[0]. Toggling flag bit 0 alone exposes any decoder that lets the unused flag leak in. Inverted-sense fields exercise both flag polarities, and the boundary headers 4'b0001 and 4'b0100 would be misclassified by a decoder that examined too few or too many top bits. Idle cycles between headers would catch a register stage that reloads without its enable, and a mis-ordered field layout would shift the enables onto the wrong slots in the patterns with a distinct selector per slot.

// File: rtl/blkhdr_pkg.sv
package blkhdr_pkg;
  typedef enum logic [1:0] {
    HK_NONE  = 2'd0,
    HK_PRED  = 2'd1,
    HK_LONG  = 2'd2,
    HK_SHORT = 2'd3
  } hdr_kind_e;

  localparam int unsigned KIND_W = 2;
endpackage

// File: rtl/blkhdr_classify.sv
module blkhdr_classify
  import blkhdr_pkg::*;
#(
  parameter int unsigned CODE_W = 4
) (
  input  logic [CODE_W-1:0] top_code,
  output hdr_kind_e         kind
);
  always_comb begin
    if (top_code[CODE_W-1]) begin
      kind = HK_NONE;
    end else if (top_code[CODE_W-2]) begin
      kind = HK_SHORT;
    end else if (top_code[CODE_W-3 -: 2] != 2'b00) begin
      kind = HK_LONG;
    end else begin
      kind = HK_PRED;
    end
  end
endmodule

// File: rtl/blkhdr_field_decode.sv
module blkhdr_field_decode #(
  parameter int unsigned FLAG_W = 8,
  localparam int unsigned SEL_W   = $clog2(FLAG_W),
  localparam int unsigned FIELD_W = SEL_W + 1
) (
  input  logic [FIELD_W-1:0] field,
  input  logic [FLAG_W-1:0]  flags,
  output logic               present,
  output logic               enable
);
  logic             sense;
  logic [SEL_W-1:0] sel;

  assign sense = field[FIELD_W-1];
  assign sel   = field[SEL_W-1:0];

  always_comb begin
    if (sel == '0) begin
      present = ~sense;
      enable  = ~sense;
    end else begin
      present = 1'b1;
      enable  = flags[sel] ^ sense;
    end
  end
endmodule

// File: rtl/blkhdr_out_reg.sv
module blkhdr_out_reg
  import blkhdr_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  hdr_kind_e            kind_d,
  input  logic [NUM_SLOTS-1:0] valid_d,
  input  logic [NUM_SLOTS-1:0] exec_d,
  output logic                 vld_q,
  output hdr_kind_e            kind_q,
  output logic [NUM_SLOTS-1:0] valid_q,
  output logic [NUM_SLOTS-1:0] exec_q
);
  hdr_kind_e            kind_n;
  logic [NUM_SLOTS-1:0] valid_n;
  logic [NUM_SLOTS-1:0] exec_n;

  always_comb begin
    kind_n  = kind_q;
    valid_n = valid_q;
    exec_n  = exec_q;
    if (load) begin
      kind_n  = kind_d;
      valid_n = valid_d;
      exec_n  = exec_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      kind_q  <= HK_NONE;
      valid_q <= '0;
      exec_q  <= '0;
    end else begin
      vld_q   <= load;
      kind_q  <= kind_n;
      valid_q <= valid_n;
      exec_q  <= exec_n;
    end
  end
endmodule

// File: rtl/blkhdr_pred_decode.sv
module blkhdr_pred_decode
  import blkhdr_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned FLAG_W    = 8,
  localparam int unsigned FIELD_W  = $clog2(FLAG_W) + 1,
  localparam int unsigned WORD_W   = FIELD_W * NUM_SLOTS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [WORD_W-1:0]    first_word,
  input  logic [FLAG_W-1:0]    cond_flags,
  output logic                 out_valid,
  output logic [KIND_W-1:0]    hdr_kind,
  output logic [NUM_SLOTS-1:0] slot_valid,
  output logic [NUM_SLOTS-1:0] slot_exec
);
  hdr_kind_e            kind_c;
  hdr_kind_e            kind_r;
  logic [NUM_SLOTS-1:0] pred_valid;
  logic [NUM_SLOTS-1:0] pred_exec;
  logic [NUM_SLOTS-1:0] valid_c;
  logic [NUM_SLOTS-1:0] exec_c;

  blkhdr_classify #(.CODE_W(FIELD_W)) u_classify (
    .top_code (first_word[WORD_W-1 -: FIELD_W]),
    .kind     (kind_c)
  );

  // Slot 0 carries the header in the predication format.
  assign pred_valid[0] = 1'b0;
  assign pred_exec[0]  = 1'b0;

  for (genvar s = 1; s < NUM_SLOTS; s++) begin : g_slot
    blkhdr_field_decode #(.FLAG_W(FLAG_W)) u_field (
      .field   (first_word[WORD_W-1-FIELD_W*s -: FIELD_W]),
      .flags   (cond_flags),
      .present (pred_valid[s]),
      .enable  (pred_exec[s])
    );
  end

  always_comb begin
    unique case (kind_c)
      HK_NONE: begin
        valid_c = '1;
        exec_c  = '1;
      end
      HK_PRED: begin
        valid_c = pred_valid;
        exec_c  = pred_exec;
      end
      default: begin
        valid_c = '0;
        exec_c  = '0;
      end
    endcase
  end

  blkhdr_out_reg #(.NUM_SLOTS(NUM_SLOTS)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (in_valid),
    .kind_d  (kind_c),
    .valid_d (valid_c),
    .exec_d  (exec_c),
    .vld_q   (out_valid),
    .kind_q  (kind_r),
    .valid_q (slot_valid),
    .exec_q  (slot_exec)
  );

  assign hdr_kind = kind_r;
endmodule

// File: rtl/blkhdr_pred_decode_chk.sv
module blkhdr_pred_decode_chk #(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned FLAG_W    = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [WORD_W-1:0]    first_word,
  input logic [FLAG_W-1:0]    cond_flags,
  input logic                 out_valid,
  input logic [1:0]           hdr_kind,
  input logic [NUM_SLOTS-1:0] slot_valid,
  input logic [NUM_SLOTS-1:0] slot_exec
);
  // R10
  out_follows_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R10
  out_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(hdr_kind) && $stable(slot_valid) && $stable(slot_exec)));

  // R1
  no_header_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && first_word[WORD_W-1]) |=>
      (hdr_kind == 2'd0 && slot_valid == '1 && slot_exec == '1));

  // R3
  pred_header_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && first_word[WORD_W-1 -: 4] == 4'b0000) |=>
      (hdr_kind == 2'd1 && !slot_valid[0] && !slot_exec[0]));

  // R5
  exec_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((slot_exec & ~slot_valid) == '0));

  // R8
  short_header_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && first_word[WORD_W-1 -: 2] == 2'b01) |=>
      (hdr_kind == 2'd3 && slot_valid == '0 && slot_exec == '0));

  // R8
  long_header_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && first_word[WORD_W-1 -: 2] == 2'b00 && first_word[WORD_W-3 -: 2] != 2'b00) |=>
      (hdr_kind == 2'd2 && slot_valid == '0 && slot_exec == '0));
endmodule

bind blkhdr_pred_decode blkhdr_pred_decode_chk #(
  .NUM_SLOTS (NUM_SLOTS),
  .WORD_W    (WORD_W),
  .FLAG_W    (FLAG_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .first_word (first_word),
  .cond_flags (cond_flags),
  .out_valid  (out_valid),
  .hdr_kind   (hdr_kind),
  .slot_valid (slot_valid),
  .slot_exec  (slot_exec)
);

// File: tb/blkhdr_pred_decode_bench.sv
module blkhdr_pred_decode_bench;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] first_word;
  logic [7:0]  cond_flags;
  logic        out_valid;
  logic [1:0]  hdr_kind;
  logic [7:0]  slot_valid;
  logic [7:0]  slot_exec;

  int unsigned tests_run;
  int unsigned tests_failed;
  bit          done;
  bit          have_last;
  logic [17:0] last_exp;

  logic [17:0] exp_q[$];
  string       tag_q[$];

  blkhdr_pred_decode u_blkhdr_pred_decode (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .first_word (first_word),
    .cond_flags (cond_flags),
    .out_valid  (out_valid),
    .hdr_kind   (hdr_kind),
    .slot_valid (slot_valid),
    .slot_exec  (slot_exec)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Expected result {kind, valid, exec}, built from the requirements.
  function automatic logic [17:0] model(input logic [31:0] w, input logic [7:0] f);
    logic [1:0] k;
    logic [7:0] v;
    logic [7:0] e;
    logic [3:0] fld;
    v = 8'h00;
    e = 8'h00;
    if (w[31]) begin
      k = 2'd0; v = 8'hFF; e = 8'hFF;           // R1
    end else if (w[31:30] == 2'b01) begin
      k = 2'd3;                                  // R2, R8
    end else if (w[29:28] != 2'b00) begin
      k = 2'd2;                                  // R2, R8
    end else begin
      k = 2'd1;                                  // R3
      for (int n = 1; n < 8; n++) begin
        fld = w[31-4*n -: 4];
        if (fld == 4'b1000) begin
          v[n] = 1'b0; e[n] = 1'b0;              // R5
        end else if (fld == 4'b0000) begin
          v[n] = 1'b1; e[n] = 1'b1;              // R4
        end else begin
          v[n] = 1'b1;
          e[n] = f[fld[2:0]] ^ fld[3];           // R6, R7
        end
      end
    end
    return {k, v, e};
  endfunction

  task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
    tests_run++;
    if (act !== exp) begin
      tests_failed++;
      $display("FAIL %s: got kind=%0d valid=%h exec=%h, expected kind=%0d valid=%h exec=%h",
               tag, act[17:16], act[15:8], act[7:0], exp[17:16], exp[15:8], exp[7:0]);
    end
  endtask

  task automatic drive(input string tag, input logic [31:0] w, input logic [7:0] f);
    @(negedge clk);
    in_valid   = 1'b1;
    first_word = w;
    cond_flags = f;
    exp_q.push_back(model(w, f));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int cycles);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      in_valid   = 1'b0;
      first_word = $urandom;
      cond_flags = $urandom;
    end
  endtask

  // Monitor: results one clock after acceptance (R10).
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check("R10 unexpected out_valid", {hdr_kind, slot_valid, slot_exec}, 18'h3FFFF);
        end else begin
          last_exp  = exp_q.pop_front();
          have_last = 1'b1;
          check(tag_q.pop_front(), {hdr_kind, slot_valid, slot_exec}, last_exp);
        end
      end else if (have_last) begin
        check("R10 hold while idle", {hdr_kind, slot_valid, slot_exec}, last_exp);
      end
    end
  end

  initial begin
    logic [31:0] lfsr;
    tests_run    = 0;
    tests_failed = 0;
    done         = 1'b0;
    have_last    = 1'b0;
    rst_n        = 1'b0;
    in_valid     = 1'b0;
    first_word   = 32'h0;
    cond_flags   = 8'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    check("R11 reset state", {hdr_kind, slot_valid, slot_exec}, 18'h0);
    tests_run++;
    if (out_valid !== 1'b0) begin
      tests_failed++;
      $display("FAIL R11: out_valid=%b expected 0", out_valid);
    end
    rst_n = 1'b1;
    idle(2);

    drive("R1 no header", 32'h8000_0000, 8'h00);
    drive("R1 no header all ones", 32'hFFFF_FFFF, 8'h55);
    drive("R2 long boundary", 32'h1234_5678, 8'hFF);
    drive("R2 long 0x3", 32'h3000_0000, 8'hFF);
    drive("R8 short header", 32'h4000_0000, 8'hFF);
    drive("R8 short header 0x7", 32'h7FFF_FFFF, 8'hFF);
    drive("R4 all unpredicated", 32'h0000_0000, 8'h00);
    drive("R5 all empty", 32'h0888_8888, 8'hFF);
    drive("R5 mixed empty", 32'h0808_0808, 8'hFE);
    drive("R6 sense0 selectors", 32'h0123_4567, 8'hAA);
    drive("R6 sense0 selectors other", 32'h0765_4321, 8'h54);
    drive("R7 sense1 selectors", 32'h09AB_CDEF, 8'hAA);
    drive("R7 sense1 all clear", 32'h0999_9999, 8'h00);
    drive("R9 flag0 low", 32'h0123_4567, 8'h3C);
    idle(3);
    drive("R9 flag0 high", 32'h0123_4567, 8'h3D);
    drive("R9 flag0 with empty", 32'h0080_8000, 8'h01);
    idle(2);
    drive("R3 slot order", 32'h0100_0000, 8'h02);
    drive("R3 slot order last", 32'h0000_000F, 8'h00);

    lfsr = 32'hACE1_1234;
    for (int i = 0; i < 150; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      drive("R6 R7 sweep", {4'b0000, lfsr[27:0]}, lfsr[31:24] ^ lfsr[7:0]);
      if (i % 17 == 0) idle(1);
    end
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      drive("R2 mixed kinds", lfsr, lfsr[15:8]);
    end
    idle(4);
    done = 1'b1;
    tests_run++;
    if (exp_q.size() != 0) begin
      tests_failed++;
      $display("FAIL R10: %0d results missing, expected 0", exp_q.size());
    end
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end
endmodule